// File: doc/BRIEF.md
# Pipelined Bus Master Phase Sequencer

This block sits on the master side of a two-stage pipelined bus. Each transfer goes through an address phase and then a data phase. A local client offers transfers with a valid/ready handshake. The sequencer drives the address and attributes, an address-phase strobe and a data-phase strobe. It reacts to two bus inputs: an address-hold input from the bus side and a transfer-acknowledge input.

The two phases are separate pipeline stages. A new transfer can occupy the address stage while the previous transfer is still in its data phase. The hold input freezes the address stage, which keeps the address steady and stops the transfer from entering its data phase. A data phase that is already running still finishes. Wait states come from cycles without an acknowledge. When an acknowledge arrives while a released address phase is waiting, the next data phase follows with no idle cycle.

Top module: `bus_phase_seq`

## Requirements
- R1: While `addr_strobe` is high and `hold_in` is high at a clock edge, `addr_strobe` stays high and `bus_addr`/`bus_attr` are unchanged in the next cycle.
- R2: While `hold_in` is high and `data_strobe` is low at a clock edge, `data_strobe` is still low in the next cycle.
- R3: A data phase stays active (`data_strobe` high) through every clock edge at which `ack_in` is low, so each such cycle adds one wait state.
- R4: The pending address phase enters its data phase at a clock edge where `addr_strobe` is high, `hold_in` is low, and either `data_strobe` is low or `ack_in` is high. `data_strobe` is then high in the next cycle.
- R5: If `hold_in` is high while a data phase is active, that data phase still ends on `ack_in`: `data_strobe` goes low and the held address phase stays put.
- R6: When `ack_in` ends a data phase and the address phase is released at the same edge, `data_strobe` stays high. With `ack_in` held high, each data phase therefore lasts exactly one clock.
- R7: `req_ready` is high exactly when the address stage is empty or is moving to the data phase in the current cycle. An accepted request (`req_valid` and `req_ready` both high at an edge) drives `addr_strobe` high and its address and attributes onto `bus_addr`/`bus_attr` in the next cycle, even while a data phase is active.
- R8: After the address phase moves to the data phase with no new request accepted at that edge, `addr_strobe` is low in the next cycle.
- R9: `ack_in` has no effect while no data phase is active.
- R10: Synchronous active-high `rst` clears both stages, so `addr_strobe`, `data_strobe` are low and `req_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a transfer |
| req_addr | input | ADDR_W | Address of the offered transfer |
| req_attr | input | ATTR_W | Attributes of the offered transfer |
| req_ready | output | 1 | Address stage can take a transfer this cycle |
| hold_in | input | 1 | Bus-side hold of the address phase |
| ack_in | input | 1 | Data-phase transfer acknowledge |
| bus_addr | output | ADDR_W | Address of the transfer in its address phase |
| bus_attr | output | ATTR_W | Attributes of the transfer in its address phase |
| addr_strobe | output | 1 | Address phase active |
| data_strobe | output | 1 | Data phase active |

## Verification
The hardest case to reach is an edge where an acknowledge ends a data phase, a held address phase is released, and a new request arrives, all in the same edge. The block must hand over both stages at once, with no bubble in either strobe. The stimulus sweeps every sequence of four cycles over all eight combinations of request, hold and acknowledge, starting from reset each time. This drives the block into every pairing of stage occupancy and input pattern, including that three-way handover. Short directed runs come first for hold during a data phase, a stray acknowledge and continuous acknowledge.

// File: rtl/bus_phase_seq_pkg.sv
package bus_phase_seq_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_ATTR_W = 4;

    // Occupancy of the two pipeline stages
    typedef enum logic [1:0] {
        PH_IDLE      = 2'b00,
        PH_ADDR_ONLY = 2'b01,
        PH_DATA_ONLY = 2'b10,
        PH_BOTH      = 2'b11
    } phase_e;

    // Address stage may hand its transfer to the data stage
    function automatic logic may_advance(input logic pend, input logic hold,
                                         input logic dact, input logic ack);
        return pend && !hold && (!dact || ack);
    endfunction

    function automatic phase_e phase_of(input logic a_act, input logic d_act);
        return phase_e'({d_act, a_act});
    endfunction

endpackage

// File: rtl/bps_addr_stage.sv
module bps_addr_stage #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ATTR_W-1:0] req_attr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
    } xfer_t;

    xfer_t slot_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            slot_q  <= '0;
        end else if (load_i) begin
            valid_q     <= 1'b1;
            slot_q.addr <= req_addr_i;
            slot_q.attr <= req_attr_i;
        end else if (advance_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = slot_q.addr;
    assign attr_o  = slot_q.attr;

    // R1: a held address phase keeps its strobe and contents
    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_q && hold_i) |=> (valid_q && $stable(addr_o) && $stable(attr_o)));

    // R8: leaving with nothing loaded empties the stage
    assert_drop_after_move_R8: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !load_i) |=> !valid_o);

endmodule

// File: rtl/bps_data_stage.sv
module bps_data_stage (
    input  logic clk,
    input  logic rst,
    input  logic advance_i,
    input  logic hold_i,
    input  logic ack_i,
    output logic valid_o
);
    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (advance_i) begin
            valid_q <= 1'b1;
        end else if (valid_q && ack_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;

    // R2: hold prevents a data phase from starting
    assert_no_entry_on_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !valid_q) |=> !valid_o);

    // R3: no acknowledge means a wait state
    assert_wait_state_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ack_i) |=> valid_o);

    // R5: hold does not stop the active data phase from ending
    assert_finish_under_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && ack_i && hold_i) |=> !valid_o);

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
    import bus_phase_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned ATTR_W = DEF_ATTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ATTR_W-1:0] req_attr,
    output logic              req_ready,
    input  logic              hold_in,
    input  logic              ack_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ATTR_W-1:0] bus_attr,
    output logic              addr_strobe,
    output logic              data_strobe
);
    logic   a_act, d_act, advance, accept;
    phase_e phase;

    assign advance   = may_advance(a_act, hold_in, d_act, ack_in);
    assign req_ready = !a_act || advance;
    assign accept    = req_valid && req_ready;
    assign phase     = phase_of(a_act, d_act);

    bps_addr_stage #(
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W)
    ) addr_stage_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .advance_i  (advance),
        .hold_i     (hold_in),
        .req_addr_i (req_addr),
        .req_attr_i (req_attr),
        .valid_o    (a_act),
        .addr_o     (bus_addr),
        .attr_o     (bus_attr)
    );

    bps_data_stage data_stage_i (
        .clk       (clk),
        .rst       (rst),
        .advance_i (advance),
        .hold_i    (hold_in),
        .ack_i     (ack_in),
        .valid_o   (d_act)
    );

    assign addr_strobe = a_act;
    assign data_strobe = d_act;

    // R4: a data phase is never entered without a prior address phase
    assert_data_needs_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> !data_strobe);

    // R6: back-to-back handover keeps the data strobe high
    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && data_strobe && ack_in && !hold_in) |=> data_strobe);

    // R7: an accepted request is presented next cycle
    assert_accept_presents_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (addr_strobe && bus_addr == $past(req_addr)
                                      && bus_attr == $past(req_attr)));

    // R9: a stray acknowledge leaves an idle bus idle
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && ack_in && !req_valid) |=> (!addr_strobe && !data_strobe));

    // R10: reset clears both stages
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!addr_strobe && !data_strobe));

endmodule

// File: tb/bus_phase_seq_tb_top.sv
module bus_phase_seq_tb_top;
    localparam int unsigned AW = 32;
    localparam int unsigned TW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, hold_in, ack_in;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_attr;
    logic          req_ready, addr_strobe, data_strobe;
    logic [AW-1:0] bus_addr;
    logic [TW-1:0] bus_attr;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // expected state derived from the requirements
    logic          ea, ed;
    logic [AW-1:0] eaddr;
    logic [TW-1:0] eattr;
    logic [AW-1:0] next_addr;

    always #5 clk = ~clk;

    bus_phase_seq #(.ADDR_W(AW), .ATTR_W(TW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_attr    (req_attr),
        .req_ready   (req_ready),
        .hold_in     (hold_in),
        .ack_in      (ack_in),
        .bus_addr    (bus_addr),
        .bus_attr    (bus_attr),
        .addr_strobe (addr_strobe),
        .data_strobe (data_strobe)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; hold_in = 1'b0; ack_in = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        ea = 1'b0; ed = 1'b0; eaddr = '0; eattr = '0;
    endtask

    // one cycle: drive at negedge, check ready, update expected, check outputs
    task automatic step(input string tag, input logic rv, input logic h, input logic k);
        logic adv, rdy, acc;
        @(negedge clk);
        req_valid = rv; hold_in = h; ack_in = k;
        req_addr  = next_addr; req_attr = next_addr[TW-1:0] ^ 4'h5;
        adv = ea && !h && (!ed || k);
        rdy = !ea || adv;
        acc = rv && rdy;
        #1;
        check({tag, "/R7"}, "req_ready", 64'(req_ready), 64'(rdy));
        if (adv)           ed = 1'b1;
        else if (ed && k)  ed = 1'b0;
        if (acc) begin
            ea = 1'b1; eaddr = req_addr; eattr = req_attr;
            next_addr = next_addr + 32'h10;
        end else if (adv) begin
            ea = 1'b0;
        end
        @(posedge clk); #1;
        check(tag, "addr_strobe", 64'(addr_strobe), 64'(ea));
        check(tag, "data_strobe", 64'(data_strobe), 64'(ed));
        if (ea) begin
            check({tag, "/R1"}, "bus_addr", 64'(bus_addr), 64'(eaddr));
            check({tag, "/R1"}, "bus_attr", 64'(bus_attr), 64'(eattr));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        next_addr = 32'h1000;
        rst = 1'b1; req_valid = 1'b0; hold_in = 1'b0; ack_in = 1'b0;
        req_addr = '0; req_attr = '0;
        do_reset();
        // R10: after reset
        check("R10", "addr_strobe", 64'(addr_strobe), 64'd0);
        check("R10", "data_strobe", 64'(data_strobe), 64'd0);
        check("R10", "req_ready",   64'(req_ready),   64'd1);

        // R9: stray acknowledge on idle bus
        step("R9", 1'b0, 1'b0, 1'b1);
        step("R9", 1'b0, 1'b1, 1'b1);

        // R2: request held off by hold before any data phase
        step("R2", 1'b1, 1'b1, 1'b0);
        step("R2", 1'b1, 1'b1, 1'b0);
        step("R2", 1'b0, 1'b1, 1'b0);
        step("R4", 1'b1, 1'b0, 1'b0);   // released: enters data phase, next accepted
        step("R3", 1'b0, 1'b0, 1'b0);   // wait state
        step("R3", 1'b0, 1'b1, 1'b0);   // wait state under hold
        step("R5", 1'b0, 1'b1, 1'b1);   // data phase ends under hold
        step("R5", 1'b0, 1'b1, 1'b0);
        step("R4", 1'b0, 1'b0, 1'b0);   // held phase released
        step("R8", 1'b0, 1'b0, 1'b1);   // done, strobe dropped

        // R6: continuous acknowledge with steady requests
        for (int i = 0; i < 8; i++) step("R6", 1'b1, 1'b0, 1'b1);
        step("R8", 1'b0, 1'b0, 1'b1);
        step("R8", 1'b0, 1'b0, 1'b1);

        // Exhaustive four-cycle sweep over request/hold/ack, each from reset
        for (int seq = 0; seq < 4096; seq++) begin
            do_reset();
            for (int c = 0; c < 4; c++) begin
                logic [2:0] v;
                v = 3'((seq >> (3 * c)) & 7);
                step("R4", v[2], v[1], v[0]);
            end
            step("R8", 1'b0, 1'b0, 1'b1);
            step("R8", 1'b0, 1'b0, 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule